// File: doc/BRIEF.md
# Sector Write-Protect Unlock Sequencer

This block sits beside a 256K x 16 word memory on an asynchronous-style bus. It watches every completed access and keeps an eight-bit register that marks each 32K-word sector as writable or locked. That register changes only after one exact ten-step pattern. The pattern is six reads at fixed addresses, then three writes, then one closing read. The first write carries the new protection byte. The second write must carry that byte's bitwise complement. Any deviation leaves the protection unchanged.

For every ordinary write, the block also drives a combinational write-inhibit signal. The memory array uses it to drop a write aimed at a locked sector. The block never stalls the bus and never changes bus data. Reads that form part of the pattern complete as normal reads.

Top module: `wp_unlock_seq`

## Requirements
- R1: `wr_inhibit` is high exactly when `ce_n` is low, `we_n` is low, and bit `addr[17:15]` of `prot_state` is 1, unless the write is one of the pattern's own writes. It is never high for a read.
- R2: While `rst_n` is low, and after reset, `prot_state` is 0, so every sector is writable.
- R3: The pattern is: reads at 24555h, 3AAAAh, 02333h, 1CCCCh, 000FFh, 3EF00h; then writes at 3AAAAh (byte P on `wdata[7:0]`), 1CCCCh (~P on `wdata[7:0]`) and 0FF00h; then a read at 00000h. A full, correct pattern loads P into `prot_state`. The new value is visible on the clock edge that registers the closing read. Only accesses with `acc_valid` high and `ce_n` low count as steps.
- R4: If the second write's `wdata[7:0]` is not the exact complement of P, the attempt is dropped and `prot_state` keeps its old value.
- R5: Any access with the wrong address or direction drops the attempt and leaves `prot_state` unchanged. This includes a seventh read where the first write is due.
- R6: The pattern may start only when the sequencer is armed. It is armed when `ce_n` has been high since the last counted access, or when the last counted access was at 00000h. Otherwise the opening 24555h read is ignored.
- R7: A mismatching access that is an armed read at 24555h restarts the pattern at its second step rather than at idle.
- R8: The pattern's three writes never raise `wr_inhibit`, even when their sectors are locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One-cycle pulse marking a completed access |
| ce_n | input | 1 | Chip enable, active low; high means precharge |
| we_n | input | 1 | Write enable, active low; high means read |
| addr | input | 18 | Word address; bits [17:15] select the sector |
| wdata | input | 16 | Write data; bits [7:0] carry the protection byte |
| prot_state | output | 8 | Per-sector lock bits; bit i locks sector i |
| wr_inhibit | output | 1 | Combinational block for an ordinary write to a locked sector |

## Verification
The assertions take certain things about the inputs for granted. Each access is marked by `acc_valid` for exactly one cycle while `ce_n` is low. `addr`, `we_n` and `wdata` are held steady throughout that cycle. Precharge is shown by `ce_n` being high with no access pulse. The bench drives every access from a single task that follows these rules. It drives only on falling edges, keeps `ce_n` low between back-to-back accesses, and raises `ce_n` for one whole cycle only when a test calls for precharge. The sweeps load every possible protection byte and probe all eight sectors. They also flip each bit of the confirmation byte in turn.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;
    localparam int ADDR_W = 18;
    localparam int STEP_W = 4;

    typedef logic [STEP_W-1:0] step_t;

    localparam step_t STEP_IDLE = 4'd0;
    localparam step_t STEP_PEND = 4'd6;
    localparam step_t STEP_CMP  = 4'd7;
    localparam step_t STEP_LAST = 4'd9;

    // address expected at each step of the unlock pattern
    function automatic logic [ADDR_W-1:0] seq_addr(input step_t s);
        case (s)
            4'd0:    return 18'h24555;
            4'd1:    return 18'h3AAAA;
            4'd2:    return 18'h02333;
            4'd3:    return 18'h1CCCC;
            4'd4:    return 18'h000FF;
            4'd5:    return 18'h3EF00;
            4'd6:    return 18'h3AAAA;
            4'd7:    return 18'h1CCCC;
            4'd8:    return 18'h0FF00;
            default: return 18'h00000;
        endcase
    endfunction

    // steps that expect a write rather than a read
    function automatic logic seq_is_wr(input step_t s);
        return (s == 4'd6) || (s == 4'd7) || (s == 4'd8);
    endfunction
endpackage

// File: rtl/wp_seq_fsm.sv
`timescale 1ns/1ps
module wp_seq_fsm
    import wp_pkg::*;
#(
    parameter int PROT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              ce_n_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PROT_W-1:0] byte_i,
    output logic              commit_o,
    output logic [PROT_W-1:0] new_prot_o,
    output logic              seq_wr_o
);
    typedef struct packed {
        step_t             step;
        logic              armed;
        logic [PROT_W-1:0] pend;
    } fsm_t;

    fsm_t st_d, st_q;
    logic hit, start, cmp_ok;

    always_comb begin
        st_d     = st_q;
        commit_o = 1'b0;
        hit      = (addr_i == seq_addr(st_q.step)) && (wr_i == seq_is_wr(st_q.step));
        start    = !wr_i && (addr_i == seq_addr(STEP_IDLE)) && st_q.armed;
        cmp_ok   = (st_q.step != STEP_CMP) || (byte_i == ~st_q.pend);
        if (acc_i) begin
            if (st_q.step == STEP_IDLE) begin
                st_d.step = start ? 4'd1 : STEP_IDLE;
            end else if (hit && cmp_ok) begin
                if (st_q.step == STEP_PEND) st_d.pend = byte_i;
                if (st_q.step == STEP_LAST) begin
                    st_d.step = STEP_IDLE;
                    commit_o  = 1'b1;
                end else begin
                    st_d.step = st_q.step + 4'd1;
                end
            end else begin
                st_d.step = start ? 4'd1 : STEP_IDLE;
            end
            st_d.armed = (addr_i == '0);
        end else if (ce_n_i) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{step: STEP_IDLE, armed: 1'b1, pend: '0};
        else        st_q <= st_d;
    end

    assign new_prot_o = st_q.pend;
    assign seq_wr_o   = !ce_n_i && wr_i && seq_is_wr(st_q.step)
                        && (addr_i == seq_addr(st_q.step));

    // R5: each counted access moves one step forward or falls back to idle / step 1
    a_r5_step_order: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && st_q.step != STEP_LAST) |=>
            (st_q.step == $past(st_q.step) + 4'd1) || (st_q.step <= 4'd1));
    // R3: without a counted access the step does not move
    a_r3_hold_when_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_i |=> $stable(st_q.step));
    // R6: an unarmed access can never open the pattern
    a_r6_arm_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !st_q.armed) |=> (st_q.step != 4'd1));
endmodule

// File: rtl/wp_prot_reg.sv
`timescale 1ns/1ps
module wp_prot_reg #(
    parameter int PROT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [PROT_W-1:0] new_i,
    output logic [PROT_W-1:0] prot_o
);
    logic [PROT_W-1:0] prot_d, prot_q;

    always_comb begin
        prot_d = prot_q;
        if (commit_i) prot_d = new_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prot_q <= '0;
        else        prot_q <= prot_d;
    end

    assign prot_o = prot_q;

    // R3: the lock bits move only on a completed pattern
    a_r3_change_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_q) |-> $past(commit_i));
    // R2: reset clears every lock bit
    a_r2_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (prot_q == '0));
endmodule

// File: rtl/wp_sector_gate.sv
`timescale 1ns/1ps
module wp_sector_gate #(
    parameter int SECT_W = 3,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic [NSECT-1:0]  prot_i,
    input  logic [SECT_W-1:0] sect_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              seq_wr_i,
    output logic              inhibit_o
);
    logic [NSECT-1:0] locked_hit;

    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        assign locked_hit[g] = prot_i[g] && (sect_i == SECT_W'(g));
    end

    always_comb begin
        inhibit_o = 1'b0;
        if (!ce_n_i && !we_n_i && !seq_wr_i) inhibit_o = |locked_hit;
    end
endmodule

// File: rtl/wp_unlock_seq.sv
`timescale 1ns/1ps
module wp_unlock_seq
    import wp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SECT_W = 3,
    localparam int NSECT = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NSECT-1:0]  prot_state,
    output logic              wr_inhibit
);
    logic              acc;
    logic              commit;
    logic              seq_wr;
    logic [NSECT-1:0]  new_prot;
    logic [SECT_W-1:0] sect;
    logic              unused_hi;

    assign acc       = acc_valid && !ce_n;
    assign sect      = addr[ADDR_W-1 -: SECT_W];
    assign unused_hi = ^wdata[DATA_W-1:NSECT];

    wp_seq_fsm #(.PROT_W(NSECT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_i      (acc),
        .ce_n_i     (ce_n),
        .wr_i       (!we_n),
        .addr_i     (addr),
        .byte_i     (wdata[NSECT-1:0]),
        .commit_o   (commit),
        .new_prot_o (new_prot),
        .seq_wr_o   (seq_wr)
    );

    wp_prot_reg #(.PROT_W(NSECT)) u_prot (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .new_i    (new_prot),
        .prot_o   (prot_state)
    );

    wp_sector_gate #(.SECT_W(SECT_W)) u_gate (
        .prot_i    (prot_state),
        .sect_i    (sect),
        .ce_n_i    (ce_n),
        .we_n_i    (we_n),
        .seq_wr_i  (seq_wr),
        .inhibit_o (wr_inhibit)
    );

    // R1: an inhibit is only raised for a write into a locked sector
    a_r1_inhibit_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_inhibit |-> (prot_state[sect] && !we_n && !ce_n));
    // R8: the pattern's own writes are never blocked
    a_r8_seq_write_free: assert property (@(posedge clk) disable iff (!rst_n)
        seq_wr |-> !wr_inhibit);
endmodule

// File: tb/sim_wp_unlock_seq.sv
`timescale 1ns/1ps
module sim_wp_unlock_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic [17:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [7:0]  prot_state;
    logic        wr_inhibit;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic last_inh;
    logic inh_s [3];

    always #2.5 clk = ~clk;

    wp_unlock_seq u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .ce_n(ce_n),
        .we_n(we_n), .addr(addr), .wdata(wdata),
        .prot_state(prot_state), .wr_inhibit(wr_inhibit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic precharge();
        @(negedge clk);
        ce_n = 1'b1; acc_valid = 1'b0; we_n = 1'b1;
    endtask

    task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d);
        @(negedge clk);
        ce_n = 1'b0; we_n = !wr; addr = a; wdata = d; acc_valid = 1'b1;
        #1 last_inh = wr_inhibit;
        @(negedge clk);
        acc_valid = 1'b0; we_n = 1'b1;
    endtask

    task automatic prefix();
        access(0, 18'h24555, 0); access(0, 18'h3AAAA, 0); access(0, 18'h02333, 0);
        access(0, 18'h1CCCC, 0); access(0, 18'h000FF, 0); access(0, 18'h3EF00, 0);
    endtask

    task automatic tail(input logic [7:0] p, input logic [7:0] c);
        access(1, 18'h3AAAA, {8'h00, p}); inh_s[0] = last_inh;
        access(1, 18'h1CCCC, {8'hFF, c}); inh_s[1] = last_inh;
        access(1, 18'h0FF00, 16'h1234);   inh_s[2] = last_inh;
        access(0, 18'h00000, 0);
    endtask

    task automatic unlock(input logic [7:0] p, input logic [7:0] c, input bit pre);
        if (pre) precharge();
        prefix();
        tail(p, c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R2 prot during reset", prot_state, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 prot after reset", prot_state, 0);
        check("R1 no inhibit at rest", wr_inhibit, 0);

        // full sweep of protection bytes and sectors
        for (int p = 0; p < 256; p++) begin
            unlock(p[7:0], ~p[7:0], 1);
            check("R3 commit byte", prot_state, p);
            for (int s = 0; s < 8; s++) begin
                access(1, 18'(s << 15) | 18'h00123, 0);
                check("R1 write inhibit", last_inh, (p >> s) & 1);
                access(0, 18'(s << 15), 0);
                check("R1 read never inhibited", last_inh, 0);
            end
        end

        // R8: all locked (FF), pattern writes still free
        unlock(8'h5A, 8'hA5, 1);
        check("R8 seq write 1", inh_s[0], 0);
        check("R8 seq write 2", inh_s[1], 0);
        check("R8 seq write 3", inh_s[2], 0);
        check("R3 commit 5A", prot_state, 8'h5A);

        // R4: each single-bit error in the confirmation byte
        for (int b = 0; b < 8; b++) begin
            unlock(8'h0F, ~8'h0F ^ 8'(1 << b), 1);
            check("R4 bad complement", prot_state, 8'h5A);
        end

        // R5: addresses out of order
        precharge();
        access(0, 18'h24555, 0); access(0, 18'h02333, 0); access(0, 18'h3AAAA, 0);
        access(0, 18'h1CCCC, 0); access(0, 18'h000FF, 0); access(0, 18'h3EF00, 0);
        tail(8'h11, 8'hEE);
        check("R5 out of order", prot_state, 8'h5A);

        // R5: seventh read where the first write is due
        precharge();
        prefix();
        access(0, 18'h3AAAA, 0);
        tail(8'h22, 8'hDD);
        check("R5 seventh read", prot_state, 8'h5A);

        // R5: wrong closing read address
        precharge();
        prefix();
        access(1, 18'h3AAAA, 16'h0044); access(1, 18'h1CCCC, 16'h00BB);
        access(1, 18'h0FF00, 0); access(0, 18'h00001, 0);
        check("R5 wrong closing read", prot_state, 8'h5A);

        // R6: chip enable held low, last access elsewhere
        access(0, 18'h12345, 0);
        unlock(8'h33, 8'hCC, 0);
        check("R6 unarmed start ignored", prot_state, 8'h5A);
        access(0, 18'h00000, 0);
        unlock(8'h33, 8'hCC, 0);
        check("R6 armed by access at zero", prot_state, 8'h33);

        // R7: restart from mid-pattern on an armed 24555h read
        precharge();
        access(0, 18'h24555, 0); access(0, 18'h3AAAA, 0); access(0, 18'h02333, 0);
        precharge();
        access(0, 18'h24555, 0);
        access(0, 18'h3AAAA, 0); access(0, 18'h02333, 0); access(0, 18'h1CCCC, 0);
        access(0, 18'h000FF, 0); access(0, 18'h3EF00, 0);
        tail(8'hC3, 8'h3C);
        check("R7 restart accepted", prot_state, 8'hC3);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL timeout act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule